// File: doc/BRIEF.md
# Two-Channel Chained-Descriptor DMA Engine

This block moves bytes between a synchronous 16-bit RAM and the byte data ports of two peripherals. It has two channels that run independently. Each channel walks a linked chain of four-word buffer descriptors that sit in the same RAM. For every buffer, the channel moves one byte per peripheral request, in the direction the descriptor selects. It then sets a done bit in the descriptor and moves on to the descriptor named by the next pointer. A next pointer of zero ends the chain.

The engine shares the RAM port with a CPU and steals cycles from it. The CPU asserts a request line, and in any cycle where that line is high the engine issues no access. When both channels want the same free cycle, a round-robin arbiter gives it to the channel that was not served last. Software starts a channel by placing the head descriptor address on the channel's head input and raising its enable bit. When a buffer completes, a per-descriptor flag decides whether the channel pulses its interrupt line.

Buffer bytes are stored one per RAM word, in the low eight bits, at consecutive word addresses. All addresses are word addresses.

Top module: `dma2ch`

## Requirements
- R1: After reset, mem_en, p_ack, irq and busy are all 0.
- R2: A rising edge of ch_en[i], with a nonzero ch_head[i], makes channel i read the four descriptor words at head+0..head+3. These words are, in order: buffer address, byte length, flags, next pointer. busy[i] is high from that point until the channel stops.
- R3: mem_en is never high in a cycle where cpu_req is high. When cpu_req is low and any channel is requesting, mem_en is high.
- R4: At most one channel is granted per cycle. When both channels request the same free cycle, the one not granted most recently wins.
- R5: With flags bit 0 = 1 (RAM to peripheral), the channel reads the buffer word for each byte and presents its low 8 bits on p_tx_data[i] while p_ack[i] is high.
- R6: With flags bit 0 = 0 (peripheral to RAM), the channel writes {8'h00, p_rx_data[i]} to the buffer word for each byte.
- R7: Each held p_req[i] yields exactly one byte. p_ack[i] is high for a single cycle, two cycles after the channel's RAM grant for that byte. Buffer addresses advance by one word per byte.
- R8: After the last byte of a buffer, the channel writes flags | 16'h8000 back to descriptor word 2, before it fetches any further descriptor.
- R9: If flags bit 1 is set, irq[i] pulses high for one cycle after the done write-back. If flags bit 1 is clear, no pulse is given.
- R10: A nonzero next pointer makes the channel fetch that descriptor. A zero next pointer stops the channel, and busy[i] falls.
- R11: A descriptor with length 0 moves no bytes. Its done bit is written back at once.
- R12: Clearing ch_en[i] stops the channel at its next wait for a request. Remaining buffer words and the descriptor's done bit are left untouched.
- R13: A channel that has stopped stays idle while ch_en[i] stays high. Only a new rising edge restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ch_en | input | 2 | Per-channel enable; a rising edge starts the channel |
| ch_head | input | 2x16 | Per-channel head descriptor word address |
| cpu_req | input | 1 | CPU uses the RAM this cycle |
| mem_en | output | 1 | RAM access strobe |
| mem_we | output | 1 | RAM write when high, read when low |
| mem_addr | output | 16 | RAM word address |
| mem_wdata | output | 16 | RAM write data |
| mem_rdata | input | 16 | RAM read data, valid the cycle after a read |
| p_req | input | 2 | Per-channel peripheral byte request, held until acknowledged |
| p_rx_data | input | 2x8 | Per-channel byte from the peripheral |
| p_ack | output | 2 | Per-channel one-cycle acknowledge |
| p_tx_data | output | 2x8 | Per-channel byte to the peripheral, valid with p_ack |
| irq | output | 2 | Per-channel completion interrupt pulse |
| busy | output | 2 | Channel is walking its chain |

## Verification
Some properties are checked by assertions on every cycle:
- the yield to the CPU, and the rule that a requested free cycle is never wasted;
- one grant at a time, given only to a requester, with the round-robin pick when both channels contend;
- the single-cycle acknowledge that lands two cycles after its grant;
- the single-cycle interrupt pulse.

Other behaviour can only be shown by the bench scenarios, using a RAM model and peripheral models:
- that the right bytes land in the right words in each direction;
- that done bits and interrupts follow the descriptor flags;
- that chains are followed and end on a zero pointer, and zero-length buffers are handled;
- that disabling stops the channel without a write-back, and that there is no restart without a new enable edge.

// File: rtl/dma2ch_pkg.sv
package dma2ch_pkg;
  localparam int NCH       = 2;
  localparam int WW        = 16;
  localparam int BW        = 8;
  localparam int DESC_LEN  = 4;
  localparam int IX_ADDR   = 0;
  localparam int IX_LEN    = 1;
  localparam int IX_FLAGS  = 2;
  localparam int IX_NEXT   = 3;
  localparam int FB_DIR_TX = 0;
  localparam int FB_IE     = 1;
  localparam int FB_DONE   = 15;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_FCAP, ST_WAIT, ST_XFER, ST_LATCH, ST_ACK, ST_WB
  } ch_state_e;

  function automatic logic [WW-1:0] mark_done(input logic [WW-1:0] f);
    logic [WW-1:0] r;
    r = f;
    r[FB_DONE] = 1'b1;
    return r;
  endfunction

  function automatic logic flag_tx(input logic [WW-1:0] f);
    return f[FB_DIR_TX];
  endfunction

  function automatic logic flag_ie(input logic [WW-1:0] f);
    return f[FB_IE];
  endfunction
endpackage

// File: rtl/dma2ch_arb.sv
module dma2ch_arb
  import dma2ch_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cpu_req,
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic           last_q
);
  always_comb begin
    gnt = '0;
    if (!cpu_req) begin
      if (req == 2'b11) gnt = last_q ? 2'b01 : 2'b10;
      else              gnt = req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= 1'b1;
    else if (gnt[0]) last_q <= 1'b0;
    else if (gnt[1]) last_q <= 1'b1;
  end
endmodule

// File: rtl/dma2ch_chan.sv
module dma2ch_chan
  import dma2ch_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] head,
  output logic          mreq,
  output logic          mwe,
  output logic [AW-1:0] maddr,
  output logic [WW-1:0] mwdata,
  input  logic          gnt,
  input  logic [WW-1:0] rdata,
  input  logic          preq,
  input  logic [BW-1:0] prx,
  output logic          pack,
  output logic [BW-1:0] ptx,
  output logic          irq,
  output logic          busy
);
  localparam int KW = $clog2(DESC_LEN);

  ch_state_e     st;
  logic [KW-1:0] k;
  logic [AW-1:0] desc_q, buf_q, next_q;
  logic [WW-1:0] len_q, flags_q;
  logic [BW-1:0] data_q;
  logic          en_q, irq_q;

  wire start = en && !en_q && (head != '0);

  always_comb begin
    mreq   = (st == ST_FETCH) || (st == ST_XFER) || (st == ST_WB);
    mwe    = (st == ST_WB) || ((st == ST_XFER) && !flag_tx(flags_q));
    maddr  = buf_q;
    mwdata = {{(WW-BW){1'b0}}, prx};
    if (st == ST_FETCH) maddr = desc_q + AW'(k);
    if (st == ST_WB) begin
      maddr  = desc_q + AW'(IX_FLAGS);
      mwdata = mark_done(flags_q);
    end
  end

  assign pack = (st == ST_ACK);
  assign ptx  = data_q;
  assign irq  = irq_q;
  assign busy = (st != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; k <= '0; desc_q <= '0; buf_q <= '0; next_q <= '0;
      len_q <= '0; flags_q <= '0; data_q <= '0; en_q <= 1'b0; irq_q <= 1'b0;
    end else begin
      en_q  <= en;
      irq_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (start) begin
          desc_q <= head;
          k      <= '0;
          st     <= ST_FETCH;
        end
        ST_FETCH: if (gnt) st <= ST_FCAP;
        ST_FCAP: begin
          unique case (int'(k))
            IX_ADDR:  buf_q   <= rdata[AW-1:0];
            IX_LEN:   len_q   <= rdata;
            IX_FLAGS: flags_q <= rdata;
            default:  next_q  <= rdata[AW-1:0];
          endcase
          if (int'(k) == DESC_LEN - 1) st <= (len_q == '0) ? ST_WB : ST_WAIT;
          else begin
            k  <= k + 1'b1;
            st <= ST_FETCH;
          end
        end
        ST_WAIT: begin
          if (!en)       st <= ST_IDLE;
          else if (preq) st <= ST_XFER;
        end
        ST_XFER: if (gnt) st <= ST_LATCH;
        ST_LATCH: begin
          data_q <= flag_tx(flags_q) ? rdata[BW-1:0] : prx;
          st     <= ST_ACK;
        end
        ST_ACK: begin
          len_q <= len_q - 1'b1;
          buf_q <= buf_q + 1'b1;
          if (len_q == WW'(1)) st <= ST_WB;
          else if (!en)        st <= ST_IDLE;
          else                 st <= ST_WAIT;
        end
        ST_WB: if (gnt) begin
          irq_q <= flag_ie(flags_q);
          if (next_q == '0) st <= ST_IDLE;
          else begin
            desc_q <= next_q;
            k      <= '0;
            st     <= ST_FETCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dma2ch.sv
module dma2ch
  import dma2ch_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NCH-1:0]          ch_en,
  input  logic [NCH-1:0][AW-1:0]  ch_head,
  input  logic                    cpu_req,
  output logic                    mem_en,
  output logic                    mem_we,
  output logic [AW-1:0]           mem_addr,
  output logic [WW-1:0]           mem_wdata,
  input  logic [WW-1:0]           mem_rdata,
  input  logic [NCH-1:0]          p_req,
  input  logic [NCH-1:0][BW-1:0]  p_rx_data,
  output logic [NCH-1:0]          p_ack,
  output logic [NCH-1:0][BW-1:0]  p_tx_data,
  output logic [NCH-1:0]          irq,
  output logic [NCH-1:0]          busy
);
  logic [NCH-1:0]         creq, cwe, gnt;
  logic [NCH-1:0][AW-1:0] caddr;
  logic [NCH-1:0][WW-1:0] cwdata;
  logic                   rr_last;

  dma2ch_arb u_arb (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req),
    .req(creq), .gnt(gnt), .last_q(rr_last)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    dma2ch_chan #(.AW(AW)) u_ch (
      .clk(clk), .rst_n(rst_n), .en(ch_en[i]), .head(ch_head[i]),
      .mreq(creq[i]), .mwe(cwe[i]), .maddr(caddr[i]), .mwdata(cwdata[i]),
      .gnt(gnt[i]), .rdata(mem_rdata),
      .preq(p_req[i]), .prx(p_rx_data[i]), .pack(p_ack[i]), .ptx(p_tx_data[i]),
      .irq(irq[i]), .busy(busy[i])
    );
  end

  always_comb begin
    mem_en    = |gnt;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    for (int i = 0; i < NCH; i++) begin
      if (gnt[i]) begin
        mem_we    = cwe[i];
        mem_addr  = caddr[i];
        mem_wdata = cwdata[i];
      end
    end
  end
endmodule

// File: rtl/dma2ch_chk.sv
module dma2ch_chk
  import dma2ch_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_req,
  input logic           mem_en,
  input logic [NCH-1:0] creq,
  input logic [NCH-1:0] gnt,
  input logic           last_q,
  input logic [NCH-1:0] pack,
  input logic [NCH-1:0] irq
);
  p_steal_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> !mem_en);
  p_no_waste_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_req && creq != '0) |-> mem_en);
  p_one_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  p_grant_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~creq) == '0);
  p_rr_to1_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (creq == 2'b11 && !cpu_req && !last_q) |-> gnt == 2'b10);
  p_rr_to0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (creq == 2'b11 && !cpu_req && last_q) |-> gnt == 2'b01);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      pack[i] |=> !pack[i]);
    p_ack_lat_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pack[i]) |-> $past(gnt[i], 2));
    p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq[i] |=> !irq[i]);
  end
endmodule

bind dma2ch dma2ch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .mem_en(mem_en),
  .creq(creq), .gnt(gnt), .last_q(rr_last), .pack(p_ack), .irq(irq)
);

// File: tb/dma2ch_test.sv
module dma2ch_test;
  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [1:0]       ch_en = '0;
  logic [1:0][15:0] ch_head = '0;
  logic             cpu_req = 1'b0;
  logic             mem_en, mem_we;
  logic [15:0]      mem_addr, mem_wdata, mem_rdata;
  logic [1:0]       p_req = '0;
  logic [1:0][7:0]  p_rx_data = '0;
  logic [1:0]       p_ack, irq, busy;
  logic [1:0][7:0]  p_tx_data;

  dma2ch uut (.*);

  always #5 clk = ~clk;

  logic [15:0] ram [0:255];
  always @(posedge clk)
    if (mem_en) begin
      if (mem_we) ram[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr[7:0]];
    end

  int total = 0, bad = 0, steal_viol = 0;
  int irq_cnt [2];
  bit noise = 0, finished = 0;
  logic [7:0] got [2][8];

  always @(negedge clk) begin
    cpu_req <= noise ? ($urandom % 3 == 0) : 1'b0;
    if (cpu_req && mem_en) steal_viol++;
  end
  always @(posedge clk) for (int i = 0; i < 2; i++) if (irq[i]) irq_cnt[i]++;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic put_desc(input int a, input int buf_a, input int len,
                          input int flags, input int nxt);
    ram[a] = 16'(buf_a); ram[a+1] = 16'(len); ram[a+2] = 16'(flags); ram[a+3] = 16'(nxt);
  endtask

  task automatic start(input int ch, input int head);
    @(negedge clk);
    ch_en[ch] = 1'b0; ch_head[ch] = 16'(head); irq_cnt[ch] = 0;
    @(negedge clk);
    ch_en[ch] = 1'b1;
  endtask

  task automatic periph(input int ch, input int n, input int rxbase);
    for (int b = 0; b < n; b++) begin
      @(negedge clk);
      p_req[ch] = 1'b1; p_rx_data[ch] = 8'(rxbase + b);
      for (int c = 0; c < 3000; c++) begin
        @(negedge clk);
        if (p_ack[ch]) break;
      end
      got[ch][b] = p_tx_data[ch];
      check(p_ack[ch] === 1'b1, "R7", "ack seen", int'(p_ack[ch]), 1);
      p_req[ch] = 1'b0;
    end
  endtask

  task automatic wait_idle(input int ch);
    for (int c = 0; c < 3000 && busy[ch]; c++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    check(mem_en === 1'b0 && p_ack === 2'b00 && irq === 2'b00 && busy === 2'b00,
          "R1", "outputs after reset", int'({mem_en, p_ack, irq, busy}), 0);
  endtask

  task automatic t_tx_single;
    put_desc(8'h10, 8'h40, 3, 16'h0003, 0);
    ram[8'h40] = 16'h55A1; ram[8'h41] = 16'h55B2; ram[8'h42] = 16'h55C3;
    start(0, 8'h10);
    @(negedge clk);
    check(busy[0] === 1'b1, "R2", "busy after enable edge", int'(busy[0]), 1);
    periph(0, 3, 0);
    check(got[0][0] == 8'hA1, "R5", "tx byte 0", got[0][0], 8'hA1);
    check(got[0][1] == 8'hB2, "R5", "tx byte 1", got[0][1], 8'hB2);
    check(got[0][2] == 8'hC3, "R5", "tx byte 2", got[0][2], 8'hC3);
    wait_idle(0);
    check(ram[8'h12] == 16'h8003, "R8", "done write-back", ram[8'h12], 16'h8003);
    check(irq_cnt[0] == 1, "R9", "irq pulses with ie", irq_cnt[0], 1);
    check(busy[0] === 1'b0, "R10", "stops on zero next", int'(busy[0]), 0);
    repeat (20) @(negedge clk);
    check(busy[0] === 1'b0 && ram[8'h12] == 16'h8003, "R13", "no restart while enable held",
          int'(busy[0]), 0);
  endtask

  task automatic t_rx_chain;
    put_desc(8'h20, 8'h60, 2, 16'h0000, 8'h28);
    put_desc(8'h28, 8'h70, 0, 16'h0002, 0);
    ram[8'h60] = 16'hFFFF; ram[8'h61] = 16'hFFFF; ram[8'h70] = 16'h1234;
    start(1, 8'h20);
    periph(1, 2, 8'h31);
    wait_idle(1);
    check(ram[8'h60] == 16'h0031, "R6", "rx word 0", ram[8'h60], 16'h0031);
    check(ram[8'h61] == 16'h0032, "R6", "rx word 1", ram[8'h61], 16'h0032);
    check(ram[8'h22] == 16'h8000, "R8", "first done", ram[8'h22], 16'h8000);
    check(ram[8'h2A] == 16'h8002, "R10", "chained descriptor done", ram[8'h2A], 16'h8002);
    check(ram[8'h70] == 16'h1234, "R11", "zero length untouched", ram[8'h70], 16'h1234);
    check(irq_cnt[1] == 1, "R9", "irq only for ie descriptor", irq_cnt[1], 1);
  endtask

  task automatic t_both_steal;
    put_desc(8'h30, 8'h80, 4, 16'h0001, 0);
    put_desc(8'h38, 8'h90, 4, 16'h0000, 0);
    for (int i = 0; i < 4; i++) ram[8'h80 + i] = 16'(8'h11 * (i + 1));
    noise = 1; steal_viol = 0;
    fork
      start(0, 8'h30);
      start(1, 8'h38);
    join
    fork
      periph(0, 4, 0);
      periph(1, 4, 8'h50);
    join
    wait_idle(0); wait_idle(1);
    noise = 0;
    for (int i = 0; i < 4; i++) begin
      check(got[0][i] == 8'(8'h11 * (i + 1)), "R4", "concurrent tx byte", got[0][i], 8'h11 * (i + 1));
      check(ram[8'h90 + i] == 16'(8'h50 + i), "R4", "concurrent rx word", ram[8'h90 + i], 8'h50 + i);
    end
    check(steal_viol == 0, "R3", "access during cpu cycle", steal_viol, 0);
    check(ram[8'h32] == 16'h8001 && ram[8'h3A] == 16'h8000, "R8", "both done",
          ram[8'h32], 16'h8001);
    check(irq_cnt[0] == 0 && irq_cnt[1] == 0, "R9", "no irq without ie",
          irq_cnt[0] + irq_cnt[1], 0);
  endtask

  task automatic t_disable;
    put_desc(8'h48, 8'hA0, 5, 16'h0002, 0);
    for (int i = 0; i < 5; i++) ram[8'hA0 + i] = 16'hEEEE;
    start(0, 8'h48);
    periph(0, 2, 8'h70);
    ch_en[0] = 1'b0;
    repeat (10) @(negedge clk);
    check(busy[0] === 1'b0, "R12", "stopped after disable", int'(busy[0]), 0);
    check(ram[8'hA1] == 16'h0071, "R12", "last byte before stop", ram[8'hA1], 16'h0071);
    check(ram[8'hA2] == 16'hEEEE, "R12", "remaining word untouched", ram[8'hA2], 16'hEEEE);
    check(ram[8'h4A] == 16'h0002, "R12", "no done on disable", ram[8'h4A], 16'h0002);
    check(irq_cnt[0] == 0, "R12", "no irq on disable", irq_cnt[0], 0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_tx_single();
    t_rx_chain();
    t_both_steal();
    t_disable();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule